// File: doc/BRIEF.md
# Burst Cycle Controller

This block sits at the synchronous front of a pipelined burst memory. On each rising clock edge it samples three chip selects, two address strobes (one meant for a processor, one for a cache controller), an advance request and a combined write request. From them it decides whether the edge starts a new access, steps or holds a running burst, or deselects the device.

It keeps the start address in a register and forms the current word address from it. Only the low two bits are counted. A static mode input picks linear or XOR-interleaved ordering. A valid flag and a registered write flag tell the downstream datapath what the current cycle is. The memory array, output drivers and power-down handling belong to other blocks.

Top module: `burst_ctrl`

## Requirements
- R1: Active-low asynchronous reset forces valid_o=0, write_o=0 and addr_o=0. After reset, step or hold edges leave valid_o low until a start edge occurs.
- R2: When cs_n_i=0, cs_hi_i=1, cs_lo_n_i=0 and strb_cpu_n_i=0 on an edge, the next outputs show valid_o=1, write_o=0 and addr_o equal to the sampled addr_i. This holds whatever strb_ctl_n_i shows.
- R3: wr_n_i has no effect on the edge that starts a cycle from strb_cpu_n_i. write_o is 0 after that edge even when wr_n_i=0.
- R4: With strb_cpu_n_i=1, strb_ctl_n_i=0 and all selects active, a cycle starts with addr_o = addr_i and valid_o=1. write_o is then 1 if wr_n_i=0 and 0 if wr_n_i=1.
- R5: cs_n_i=1 masks strb_cpu_n_i. With strb_ctl_n_i=1 the edge acts as a step or hold. With strb_ctl_n_i=0 and cs_n_i=1 the device is deselected (valid_o=0, write_o=0).
- R6: If any unmasked strobe is low while cs_hi_i=0 or cs_lo_n_i=1, the device is deselected: valid_o=0, write_o=0, and addr_o keeps its value.
- R7: With no effective strobe and adv_n_i=0 during a burst, the burst moves to its next word. write_o takes the value !wr_n_i of that edge.
- R8: With no effective strobe and adv_n_i=1 during a burst, addr_o holds its value. write_o takes the value !wr_n_i.
- R9: adv_n_i is ignored on a start edge from strb_cpu_n_i. The burst always begins at the loaded address.
- R10: Bits above bit 1 of addr_o never change during a burst. After four steps the low bits return to the start value.
- R11: With mode_i=0, the low two bits are (start + count) mod 4.
- R12: With mode_i=1, the low two bits are start XOR count.
- R13: While valid_o=0, edges with no effective strobe change neither valid_o nor addr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Primary chip select, active low; also masks the processor strobe |
| cs_hi_i | input | 1 | Secondary chip select, active high |
| cs_lo_n_i | input | 1 | Secondary chip select, active low |
| strb_cpu_n_i | input | 1 | Processor address strobe, active low |
| strb_ctl_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| wr_n_i | input | 1 | Combined write request, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| addr_i | input | AW | External word address |
| addr_o | output | AW | Current word address |
| valid_o | output | 1 | An access is active |
| write_o | output | 1 | Current cycle is a write |

## Verification
The hardest case is an edge where the primary select is high while the processor strobe is low. The block must treat this as a burst continuation, not a start and not a deselect. The stimulus first runs a read burst to its wrap point. It then applies exactly that pattern with the write request low and checks that the burst steps and turns into a write. A deselect edge follows, and then advance edges while idle, which show that the held address does not move.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [2:0] {
    CYC_DESEL,
    CYC_START_RD,
    CYC_START_WR,
    CYC_STEP,
    CYC_HOLD
  } cyc_e;
endpackage

// File: rtl/burst_decode.sv
module burst_decode
  import burst_pkg::*;
(
  input  logic cs_n_i,
  input  logic cs_hi_i,
  input  logic cs_lo_n_i,
  input  logic strb_cpu_n_i,
  input  logic strb_ctl_n_i,
  input  logic adv_n_i,
  input  logic wr_n_i,
  output cyc_e cyc_o
);
  logic sec_ok;
  logic cpu_eff;

  assign sec_ok  = cs_hi_i & ~cs_lo_n_i;
  // primary select high masks the processor strobe
  assign cpu_eff = ~strb_cpu_n_i & ~cs_n_i;

  always_comb begin
    if (cpu_eff) begin
      cyc_o = sec_ok ? CYC_START_RD : CYC_DESEL;
    end else if (!strb_ctl_n_i) begin
      if (!cs_n_i && sec_ok) cyc_o = wr_n_i ? CYC_START_RD : CYC_START_WR;
      else                   cyc_o = CYC_DESEL;
    end else begin
      cyc_o = adv_n_i ? CYC_HOLD : CYC_STEP;
    end
  end
endmodule

// File: rtl/burst_state.sv
module burst_state
  import burst_pkg::*;
#(
  parameter int AW = 18,
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cyc_e          cyc_i,
  input  logic          wr_n_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] base_o,
  output logic [CW-1:0] cnt_o,
  output logic          valid_o,
  output logic          write_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o  <= '0;
      cnt_o   <= '0;
      valid_o <= 1'b0;
      write_o <= 1'b0;
    end else begin
      unique case (cyc_i)
        CYC_START_RD, CYC_START_WR: begin
          base_o  <= addr_i;
          cnt_o   <= '0;
          valid_o <= 1'b1;
          write_o <= (cyc_i == CYC_START_WR);
        end
        CYC_DESEL: begin
          valid_o <= 1'b0;
          write_o <= 1'b0;
        end
        CYC_STEP: begin
          if (valid_o) begin
            cnt_o   <= cnt_o + 1'b1;
            write_o <= ~wr_n_i;
          end
        end
        CYC_HOLD: begin
          if (valid_o) write_o <= ~wr_n_i;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/burst_order.sv
module burst_order #(
  parameter int CW = 2
) (
  input  logic          mode_i,
  input  logic [CW-1:0] start_i,
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] word_o
);
  logic [CW-1:0] lin;
  logic [CW-1:0] ilv;

  assign lin    = start_i + cnt_i;
  assign ilv    = start_i ^ cnt_i;
  assign word_o = mode_i ? ilv : lin;
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int AW = 18,
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_n_i,
  input  logic          cs_hi_i,
  input  logic          cs_lo_n_i,
  input  logic          strb_cpu_n_i,
  input  logic          strb_ctl_n_i,
  input  logic          adv_n_i,
  input  logic          wr_n_i,
  input  logic          mode_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o,
  output logic          valid_o,
  output logic          write_o
);
  cyc_e          cyc;
  logic [AW-1:0] base;
  logic [CW-1:0] cnt;
  logic [CW-1:0] word;

  burst_decode u_dec (
    .cs_n_i       (cs_n_i),
    .cs_hi_i      (cs_hi_i),
    .cs_lo_n_i    (cs_lo_n_i),
    .strb_cpu_n_i (strb_cpu_n_i),
    .strb_ctl_n_i (strb_ctl_n_i),
    .adv_n_i      (adv_n_i),
    .wr_n_i       (wr_n_i),
    .cyc_o        (cyc)
  );

  burst_state #(.AW(AW), .CW(CW)) u_st (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cyc_i   (cyc),
    .wr_n_i  (wr_n_i),
    .addr_i  (addr_i),
    .base_o  (base),
    .cnt_o   (cnt),
    .valid_o (valid_o),
    .write_o (write_o)
  );

  burst_order #(.CW(CW)) u_ord (
    .mode_i  (mode_i),
    .start_i (base[CW-1:0]),
    .cnt_i   (cnt),
    .word_o  (word)
  );

  assign addr_o = {base[AW-1:CW], word};
endmodule

// File: rtl/burst_ctrl_chk.sv
module burst_ctrl_chk #(
  parameter int AW = 18,
  parameter int CW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_n_i,
  input logic          cs_hi_i,
  input logic          cs_lo_n_i,
  input logic          strb_cpu_n_i,
  input logic          strb_ctl_n_i,
  input logic          adv_n_i,
  input logic          wr_n_i,
  input logic [AW-1:0] addr_i,
  input logic [AW-1:0] addr_o,
  input logic          valid_o,
  input logic          write_o
);
  logic all_sel;
  logic no_strb;
  assign all_sel = ~cs_n_i & cs_hi_i & ~cs_lo_n_i;
  assign no_strb = strb_ctl_n_i & (strb_cpu_n_i | cs_n_i);

  // R2
  cpu_start_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_sel && !strb_cpu_n_i) |=> (valid_o && !write_o && addr_o == $past(addr_i)));

  // R4
  ctl_start_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_sel && strb_cpu_n_i && !strb_ctl_n_i) |=> (valid_o && write_o == !$past(wr_n_i)));

  // R6
  desel_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && (!strb_cpu_n_i || !strb_ctl_n_i) && (!cs_hi_i || cs_lo_n_i))
      |=> (!valid_o && !write_o));

  // R8
  hold_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && no_strb && adv_n_i) |=> $stable(addr_o));

  // R10
  upper_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && no_strb) |=> $stable(addr_o[AW-1:CW]));
endmodule

bind burst_ctrl burst_ctrl_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_n_i       (cs_n_i),
  .cs_hi_i      (cs_hi_i),
  .cs_lo_n_i    (cs_lo_n_i),
  .strb_cpu_n_i (strb_cpu_n_i),
  .strb_ctl_n_i (strb_ctl_n_i),
  .adv_n_i      (adv_n_i),
  .wr_n_i       (wr_n_i),
  .addr_i       (addr_i),
  .addr_o       (addr_o),
  .valid_o      (valid_o),
  .write_o      (write_o)
);

// File: tb/sim_burst_ctrl.sv
module sim_burst_ctrl;
  localparam int AW = 18;
  localparam int NV = 20;
  localparam int VW = 8 + AW + 2 + AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cs_n, cs_hi, cs_lo_n, cpu_n, ctl_n, adv_n, wr_n, mode;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;
  logic          valid, write;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  burst_ctrl #(.AW(AW), .CW(2)) u0 (
    .clk_i (clk), .rst_ni (rst_ni), .cs_n_i (cs_n), .cs_hi_i (cs_hi),
    .cs_lo_n_i (cs_lo_n), .strb_cpu_n_i (cpu_n), .strb_ctl_n_i (ctl_n),
    .adv_n_i (adv_n), .wr_n_i (wr_n), .mode_i (mode), .addr_i (addr_in),
    .addr_o (addr_out), .valid_o (valid), .write_o (write)
  );

  // ctrl bits: cs_n cs_hi cs_lo_n cpu_n ctl_n adv_n wr_n mode | addr | exp valid,write | exp addr
  localparam logic [VW-1:0] VEC [NV] = '{
    {8'b01000000, 18'h3C001, 2'b10, 18'h3C001},
    {8'b01011010, 18'h15555, 2'b10, 18'h3C002},
    {8'b01011010, 18'h15555, 2'b10, 18'h3C003},
    {8'b01011110, 18'h15555, 2'b10, 18'h3C003},
    {8'b01011010, 18'h15555, 2'b10, 18'h3C000},
    {8'b01011010, 18'h15555, 2'b10, 18'h3C001},
    {8'b11001000, 18'h00000, 2'b11, 18'h3C002},
    {8'b00001010, 18'h00000, 2'b00, 18'h3C002},
    {8'b01011010, 18'h15555, 2'b00, 18'h3C002},
    {8'b01010001, 18'h00002, 2'b11, 18'h00002},
    {8'b01011001, 18'h15555, 2'b11, 18'h00003},
    {8'b01011001, 18'h15555, 2'b11, 18'h00000},
    {8'b01011001, 18'h15555, 2'b11, 18'h00001},
    {8'b01011001, 18'h15555, 2'b11, 18'h00002},
    {8'b01110001, 18'h15555, 2'b00, 18'h00002},
    {8'b01010010, 18'h3FFFE, 2'b10, 18'h3FFFE},
    {8'b11010010, 18'h15555, 2'b00, 18'h3FFFE},
    {8'b01001100, 18'h3FFFE, 2'b10, 18'h3FFFE},
    {8'b01011010, 18'h15555, 2'b10, 18'h3FFFF},
    {8'b01011010, 18'h15555, 2'b10, 18'h3FFFC}
  };
  // vector 1 also covers R2, vector 18 covers R3
  localparam logic [23:0] TAG [NV] = '{
    "R3 ", "R7 ", "R11", "R8 ", "R11", "R10", "R5 ", "R6 ", "R13", "R4 ",
    "R12", "R12", "R12", "R10", "R6 ", "R4 ", "R5 ", "R9 ", "R11", "R10"
  };

  task automatic drive(input logic [7:0] c, input logic [AW-1:0] a);
    {cs_n, cs_hi, cs_lo_n, cpu_n, ctl_n, adv_n, wr_n, mode} = c;
    addr_in = a;
  endtask

  task automatic check(input logic [23:0] tag, input logic ev, input logic ew,
                       input logic [AW-1:0] ea);
    checks++;
    if (valid !== ev || write !== ew || addr_out !== ea) begin
      errors++;
      $display("FAIL %s: valid/write/addr = %b/%b/%h, expected %b/%b/%h",
               tag, valid, write, addr_out, ev, ew, ea);
    end
  endtask

  task automatic step(input logic [7:0] c, input logic [AW-1:0] a);
    @(negedge clk);
    drive(c, a);
    @(posedge clk);
    #1;
  endtask

  initial begin
    drive(8'b01011110, '0);
    repeat (3) @(posedge clk);
    #1;
    check("R1 ", 1'b0, 1'b0, '0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][VW-1 -: 8], VEC[i][VW-9 -: AW]);
      check(TAG[i], VEC[i][AW+1], VEC[i][AW], VEC[i][AW-1:0]);
    end

    // R2: processor strobe start with controller strobe also low
    step(8'b01000010, 18'h2ABCD);
    check("R2 ", 1'b1, 1'b0, 18'h2ABCD);

    // R1: reset mid-burst, then step edges stay idle
    step(8'b01011010, 18'h15555);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R1 ", 1'b0, 1'b0, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    step(8'b01011010, 18'h15555);
    check("R1 ", 1'b0, 1'b0, '0);

    // R13: hold while idle
    step(8'b01011110, 18'h15555);
    check("R13", 1'b0, 1'b0, '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule